// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM with Selectable Read Latency

This block is a synchronous memory of 4096 words of 9 bits with two symmetric ports, left and right. Each port has its own clock and may read or write any word while the other port does the same. Every request input (address, write data, port select and read/write direction) is captured by an input register on the rising edge of that port's clock, and only the captured copy acts on the storage.

Each port picks its read latency with a mode input. In flow-through mode the word addressed by the captured request reaches the data output right after the capture edge. In pipelined mode the word is taken into an extra output register at the next edge, which adds one cycle but keeps the output path short for high clock rates. A per-port clock enable freezes all registers of that port, the output register included. A per-port output enable decides whether the port presents data; its off state (high impedance on a board) is modelled by a data-valid flag at 0 with the data bus at zero.

Top module: `dpr_pipe_ram`

## Requirements
- R1: The store holds 2**12 words of 9 bits; a word written through either port at any address from 0 to 4095 is read back unchanged through either port.
- R2: A request captured on an enabled rising edge with port select high and read/write direction low (0 = write, 1 = read) stores the captured data into the word at the captured address, and commits it at the next enabled edge of that port; with port select low nothing is written and no read takes place.
- R3: With the mode input at 0 (flow-through), the word for a read captured at edge k is on the data output with the valid flag high from edge k until the next enabled edge.
- R4: With the mode input at 1 (pipelined), the word for a read captured at edge k is on the data output with the valid flag high from edge k+1.
- R5: While a port's clock enable is low at an edge, that port's input and output registers keep their values, no new request is taken, a pending write is not committed before the next enabled edge, and the pipelined output does not change.
- R6: With output enable low the valid flag is 0 and the data output is all zeros; toggling it changes no stored word or register.
- R7: When the last captured request of a port is not a read (write or deselect), the valid flag is 0 and the data output is all zeros, regardless of mode for the flow-through path and one cycle later for the pipelined path.
- R8: When both ports commit writes to the same address on the same edge, the word keeps the left port's data.
- R9: A read on one port of the address the other port writes on the same edge returns the word as it was before that write, in both modes.
- R10: While the active-low reset is low, and for two edges after it is released, both valid flags are 0 and the pipelined output registers are cleared; stored words are left undefined.
- R11: Both ports can access different addresses on every edge at the same time, each getting its own result with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each port's clock domain |
| l_clk | input | 1 | Left port clock |
| l_cken | input | 1 | Left clock enable, 1 = registers advance |
| l_cs | input | 1 | Left port select, 1 = access this edge |
| l_rnw | input | 1 | Left direction, 1 = read, 0 = write |
| l_oe | input | 1 | Left output enable |
| l_pipe | input | 1 | Left read mode, 0 = flow-through, 1 = pipelined |
| l_addr | input | 12 | Left word address |
| l_din | input | 9 | Left write data |
| l_dout | output | 9 | Left read data, zero when not valid |
| l_dvalid | output | 1 | Left read data valid (0 models a released bus) |
| r_clk | input | 1 | Right port clock |
| r_cken | input | 1 | Right clock enable |
| r_cs | input | 1 | Right port select |
| r_rnw | input | 1 | Right direction, 1 = read, 0 = write |
| r_oe | input | 1 | Right output enable |
| r_pipe | input | 1 | Right read mode, 0 = flow-through, 1 = pipelined |
| r_addr | input | 12 | Right word address |
| r_din | input | 9 | Right write data |
| r_dout | output | 9 | Right read data, zero when not valid |
| r_dvalid | output | 1 | Right read data valid |

## Verification
The bench hunts for same-edge collisions: both ports writing one word, where a design that let the right port win or merged the two values would return the wrong word, and a read racing a write on the other port, where a design that forwarded the new value would show fresh data one cycle early. It freezes a port with its clock enable while a write is pending and while the pipelined output holds a word, so a design that repeated the write, dropped it, or let the output register slip would disagree with the reference. It toggles output enable and read mode mid-stream and releases reset while reads are requested, so a wrong latency count, a valid flag leaking through a write cycle, or an early exit from reset shows up as a one-cycle shift.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 9;
  localparam int NUM_PORTS = 2;

  // read latency selection per port
  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/dpr_port_in.sv
module dpr_port_in #(
  parameter int AW = dpr_pkg::ADDR_W,
  parameter int DW = dpr_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cken,
  input  logic          cs_i,
  input  logic          rnw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output logic          wr_go,
  output logic          rd_act
);

  logic          cs_q,   cs_d;
  logic          rnw_q,  rnw_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] din_d;

  // next state: capture only on an enabled edge
  always_comb begin
    cs_d   = cs_q;
    rnw_d  = rnw_q;
    addr_d = addr_q;
    din_d  = din_q;
    if (cken) begin
      cs_d   = cs_i;
      rnw_d  = rnw_i;
      addr_d = addr_i;
      din_d  = din_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cs_q   <= 1'b0;
      rnw_q  <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      cs_q   <= cs_d;
      rnw_q  <= rnw_d;
      addr_q <= addr_d;
      din_q  <= din_d;
    end
  end

  // a captured write commits on the next enabled edge only
  assign wr_go  = cken & cs_q & ~rnw_q;
  assign rd_act = cs_q & rnw_q;

endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int AW  = dpr_pkg::ADDR_W,
  parameter int DW  = dpr_pkg::DATA_W,
  parameter int NRD = dpr_pkg::NUM_PORTS + 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
  end

endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out #(
  parameter int DW = dpr_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cken,
  input  logic          mode_i,
  input  logic          oe_i,
  input  logic          rd_act,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] dout,
  output logic          dvalid
);

  import dpr_pkg::*;

  logic [DW-1:0] pdata_q, pdata_d;
  logic          pvld_q,  pvld_d;
  rd_mode_e      mode;
  logic [DW-1:0] sel_data;
  logic          sel_vld;

  assign mode = rd_mode_e'(mode_i);

  always_comb begin
    pdata_d = pdata_q;
    pvld_d  = pvld_q;
    if (cken) begin
      pdata_d = arr_word;
      pvld_d  = rd_act;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pdata_q <= '0;
      pvld_q  <= 1'b0;
    end else begin
      pdata_q <= pdata_d;
      pvld_q  <= pvld_d;
    end
  end

  always_comb begin
    if (mode == RD_PIPE) begin
      sel_data = pdata_q;
      sel_vld  = pvld_q;
    end else begin
      sel_data = arr_word;
      sel_vld  = rd_act;
    end
  end

  assign dvalid = oe_i & sel_vld;
  assign dout   = dvalid ? sel_data : '0;

endmodule

// File: rtl/dpr_pipe_ram.sv
module dpr_pipe_ram #(
  parameter int AW = dpr_pkg::ADDR_W,
  parameter int DW = dpr_pkg::DATA_W
) (
  input  logic          rst_n,
  input  logic          l_clk,
  input  logic          l_cken,
  input  logic          l_cs,
  input  logic          l_rnw,
  input  logic          l_oe,
  input  logic          l_pipe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  output logic [DW-1:0] l_dout,
  output logic          l_dvalid,
  input  logic          r_clk,
  input  logic          r_cken,
  input  logic          r_cs,
  input  logic          r_rnw,
  input  logic          r_oe,
  input  logic          r_pipe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  output logic [DW-1:0] r_dout,
  output logic          r_dvalid
);

  localparam int NP  = dpr_pkg::NUM_PORTS;
  localparam int NRD = NP + 1;   // one read per port plus one for write mixing

  logic [NP-1:0] clk_v, cken_v, cs_v, rnw_v, oe_v, mode_v;
  logic [NP-1:0] srst_v, wr_go, wr_ok, rd_act, dvalid_v;
  logic [AW-1:0] addr_v [NP];
  logic [AW-1:0] addr_q [NP];
  logic [DW-1:0] din_v  [NP];
  logic [DW-1:0] din_q  [NP];
  logic [DW-1:0] rd_word[NP];
  logic [DW-1:0] dout_v [NP];
  logic [DW-1:0] bank_wd[NP];
  logic [NRD-1:0][AW-1:0] bank_ra [NP];
  logic [NRD-1:0][DW-1:0] bank_rd [NP];

  assign clk_v  = {r_clk,  l_clk};
  assign cken_v = {r_cken, l_cken};
  assign cs_v   = {r_cs,   l_cs};
  assign rnw_v  = {r_rnw,  l_rnw};
  assign oe_v   = {r_oe,   l_oe};
  assign mode_v = {r_pipe, l_pipe};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;
  assign din_v[0]  = l_din;
  assign din_v[1]  = r_din;

  // same-edge write to one word: the left port keeps it
  assign wr_ok[0] = wr_go[0];
  assign wr_ok[1] = wr_go[1] & ~(wr_go[0] & (addr_q[0] == addr_q[1]));

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int OTH = NP - 1 - p;

    dpr_rst_sync u_rst (
      .clk    (clk_v[p]),
      .arst_n (rst_n),
      .srst_n (srst_v[p])
    );

    dpr_port_in #(.AW(AW), .DW(DW)) u_in (
      .clk    (clk_v[p]),
      .srst_n (srst_v[p]),
      .cken   (cken_v[p]),
      .cs_i   (cs_v[p]),
      .rnw_i  (rnw_v[p]),
      .addr_i (addr_v[p]),
      .din_i  (din_v[p]),
      .addr_q (addr_q[p]),
      .din_q  (din_q[p]),
      .wr_go  (wr_go[p]),
      .rd_act (rd_act[p])
    );

    // bank p: slots 0..NP-1 serve the readers, slot NP serves the other writer
    for (genvar k = 0; k < NP; k++) begin : g_ra
      assign bank_ra[p][k] = addr_q[k];
    end
    assign bank_ra[p][NP] = addr_q[OTH];

    // each bank stores data xor the other bank's word at that address
    assign bank_wd[p] = din_q[p] ^ bank_rd[OTH][NP];

    dpr_bank #(.AW(AW), .DW(DW), .NRD(NRD)) u_bank (
      .clk   (clk_v[p]),
      .we    (wr_ok[p]),
      .waddr (addr_q[p]),
      .wdata (bank_wd[p]),
      .raddr (bank_ra[p]),
      .rdata (bank_rd[p])
    );

    assign rd_word[p] = bank_rd[0][p] ^ bank_rd[1][p];

    dpr_port_out #(.DW(DW)) u_out (
      .clk      (clk_v[p]),
      .srst_n   (srst_v[p]),
      .cken     (cken_v[p]),
      .mode_i   (mode_v[p]),
      .oe_i     (oe_v[p]),
      .rd_act   (rd_act[p]),
      .arr_word (rd_word[p]),
      .dout     (dout_v[p]),
      .dvalid   (dvalid_v[p])
    );
  end

  assign l_dout   = dout_v[0];
  assign r_dout   = dout_v[1];
  assign l_dvalid = dvalid_v[0];
  assign r_dvalid = dvalid_v[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int DW = dpr_pkg::DATA_W
) (
  input logic          rst_n,
  input logic          l_clk,
  input logic          l_cken,
  input logic          l_cs,
  input logic          l_rnw,
  input logic          l_oe,
  input logic          l_pipe,
  input logic [DW-1:0] l_dout,
  input logic          l_dvalid,
  input logic          r_clk,
  input logic          r_cken,
  input logic          r_cs,
  input logic          r_rnw,
  input logic          r_oe,
  input logic          r_pipe,
  input logic [DW-1:0] r_dout,
  input logic          r_dvalid
);

  // edges since reset release, saturating; 3 means the port is running
  logic [1:0] l_cnt, r_cnt;
  logic       l_ok, r_ok;

  always_ff @(posedge l_clk or negedge rst_n) begin
    if (!rst_n)               l_cnt <= 2'd0;
    else if (l_cnt != 2'd3)   l_cnt <= l_cnt + 2'd1;
  end

  always_ff @(posedge r_clk or negedge rst_n) begin
    if (!rst_n)               r_cnt <= 2'd0;
    else if (r_cnt != 2'd3)   r_cnt <= r_cnt + 2'd1;
  end

  assign l_ok = (l_cnt == 2'd3);
  assign r_ok = (r_cnt == 2'd3);

  a_r10_reset_l: assert property (@(posedge l_clk) !rst_n |=> !l_dvalid);
  a_r10_reset_r: assert property (@(posedge r_clk) !rst_n |=> !r_dvalid);

  a_r6_oe_off_l: assert property (@(posedge l_clk) disable iff (!rst_n)
    !l_oe |-> (!l_dvalid && l_dout == '0));
  a_r6_oe_off_r: assert property (@(posedge r_clk) disable iff (!rst_n)
    !r_oe |-> (!r_dvalid && r_dout == '0));

  a_r3_flow_read_l: assert property (@(posedge l_clk) disable iff (!rst_n)
    (l_ok && l_cken && l_cs && l_rnw) |=> ((l_oe && !l_pipe) -> l_dvalid));
  a_r3_flow_read_r: assert property (@(posedge r_clk) disable iff (!rst_n)
    (r_ok && r_cken && r_cs && r_rnw) |=> ((r_oe && !r_pipe) -> r_dvalid));

  a_r4_pipe_read_l: assert property (@(posedge l_clk) disable iff (!rst_n)
    (l_ok && l_cken && $past(l_cken && l_cs && l_rnw)) |=> ((l_oe && l_pipe) -> l_dvalid));
  a_r4_pipe_read_r: assert property (@(posedge r_clk) disable iff (!rst_n)
    (r_ok && r_cken && $past(r_cken && r_cs && r_rnw)) |=> ((r_oe && r_pipe) -> r_dvalid));

  a_r7_nonread_l: assert property (@(posedge l_clk) disable iff (!rst_n)
    (l_ok && l_cken && !(l_cs && l_rnw)) |=> (!l_pipe -> !l_dvalid));
  a_r7_nonread_r: assert property (@(posedge r_clk) disable iff (!rst_n)
    (r_ok && r_cken && !(r_cs && r_rnw)) |=> (!r_pipe -> !r_dvalid));

  a_r5_hold_l: assert property (@(posedge l_clk) disable iff (!rst_n)
    (!l_cken && l_pipe && l_oe) |=> ((l_pipe && l_oe) -> $stable({l_dvalid, l_dout})));
  a_r5_hold_r: assert property (@(posedge r_clk) disable iff (!rst_n)
    (!r_cken && r_pipe && r_oe) |=> ((r_pipe && r_oe) -> $stable({r_dvalid, r_dout})));

endmodule

bind dpr_pipe_ram dpr_checker #(.DW(DW)) i_chk (.*);

// File: tb/test_dpr_pipe_ram.sv
module test_dpr_pipe_ram;

  localparam int AW    = 12;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n;
  logic          b_cken[2], b_cs[2], b_rnw[2], b_oe[2], b_pipe[2];
  logic [AW-1:0] b_addr[2];
  logic [DW-1:0] b_din[2];
  logic [DW-1:0] l_dout, r_dout;
  logic          l_dvalid, r_dvalid;

  dpr_pipe_ram i_dpr_pipe_ram (
    .rst_n    (rst_n),
    .l_clk    (clk),
    .l_cken   (b_cken[0]),
    .l_cs     (b_cs[0]),
    .l_rnw    (b_rnw[0]),
    .l_oe     (b_oe[0]),
    .l_pipe   (b_pipe[0]),
    .l_addr   (b_addr[0]),
    .l_din    (b_din[0]),
    .l_dout   (l_dout),
    .l_dvalid (l_dvalid),
    .r_clk    (clk),
    .r_cken   (b_cken[1]),
    .r_cs     (b_cs[1]),
    .r_rnw    (b_rnw[1]),
    .r_oe     (b_oe[1]),
    .r_pipe   (b_pipe[1]),
    .r_addr   (b_addr[1]),
    .r_din    (b_din[1]),
    .r_dout   (r_dout),
    .r_dvalid (r_dvalid)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R10";
  bit    armed = 1'b0;

  // behavioural reference: -1 marks an unknown word
  int mm [DEPTH];
  bit m_cs[2], m_rnw[2], m_pv[2];
  int m_addr[2], m_din[2], m_pd[2];
  int m_run;

  always @(posedge clk or negedge rst_n) begin
    int  pre[2];
    bit  wr[2];
    if (!rst_n || m_run < 2) begin
      if (!rst_n) m_run = 0;
      else        m_run = m_run + 1;
      for (int p = 0; p < 2; p++) begin
        m_cs[p] = 0; m_rnw[p] = 1; m_addr[p] = 0; m_din[p] = 0;
        m_pd[p] = 0; m_pv[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        pre[p] = mm[m_addr[p]];
        wr[p]  = b_cken[p] && m_cs[p] && !m_rnw[p];
        if (b_cken[p]) begin
          m_pd[p] = pre[p];
          m_pv[p] = m_cs[p] && m_rnw[p];
        end
      end
      if (wr[1]) mm[m_addr[1]] = m_din[1];
      if (wr[0]) mm[m_addr[0]] = m_din[0];   // left written last: left wins
      for (int p = 0; p < 2; p++) begin
        if (b_cken[p]) begin
          m_cs[p] = b_cs[p]; m_rnw[p] = b_rnw[p];
          m_addr[p] = int'(b_addr[p]); m_din[p] = int'(b_din[p]);
        end
      end
    end
  end

  task automatic chk(input int p, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s port%0d %s actual=%0d expected=%0d", tag, p, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      for (int p = 0; p < 2; p++) begin
        bit ev;
        int ed;
        int av, ad;
        ev = rst_n && b_oe[p] && (b_pipe[p] ? m_pv[p] : (m_cs[p] && m_rnw[p]));
        ed = !ev ? 0 : (b_pipe[p] ? m_pd[p] : mm[m_addr[p]]);
        av = (p == 0) ? int'(l_dvalid) : int'(r_dvalid);
        ad = (p == 0) ? int'(l_dout)   : int'(r_dout);
        chk(p, "dvalid", av, int'(ev));
        if (ed >= 0) chk(p, "dout", ad, ed);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic drv(input int p, input bit cs, input bit rnw, input int addr, input int din);
    b_cs[p]   = cs;
    b_rnw[p]  = rnw;
    b_addr[p] = AW'(addr);
    b_din[p]  = DW'(din);
  endtask

  task automatic idle();
    drv(0, 0, 1, 0, 0);
    drv(1, 0, 1, 0, 0);
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL %s watchdog actual=running expected=finished", tag);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    for (int a = 0; a < DEPTH; a++) mm[a] = -1;
    for (int p = 0; p < 2; p++) begin
      b_cken[p] = 1; b_oe[p] = 1; b_pipe[p] = 0;
      drv(p, 0, 1, 0, 0);
    end
    rst_n = 1'b1;
    #3 rst_n = 1'b0;
    armed = 1'b1;

    // R10: reads requested during and right after reset give nothing
    tag = "R10";
    drv(0, 1, 1, 5, 0); drv(1, 1, 1, 6, 0);
    b_pipe[1] = 1;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    idle(); b_pipe[1] = 0;
    tick();

    // R11: both ports write separate regions every edge
    tag = "R11";
    for (int i = 0; i < 64; i++) begin
      drv(0, 1, 0, i,          (i * 37 + 5) & 511);
      drv(1, 1, 0, 4095 - i,   (i * 53 + 100) & 511);
      tick();
    end

    // R3: flow-through reads crosswise
    tag = "R3";
    for (int i = 0; i < 64; i++) begin
      drv(0, 1, 1, 4095 - i, 0);
      drv(1, 1, 1, i, 0);
      tick();
    end

    // R4: pipelined reads
    tag = "R4";
    b_pipe[0] = 1; b_pipe[1] = 1;
    for (int i = 0; i < 64; i++) begin
      drv(0, 1, 1, i, 0);
      drv(1, 1, 1, 4095 - i, 0);
      tick();
    end
    idle(); tick(); tick();

    // R1: address extremes through opposite ports
    tag = "R1";
    b_pipe[0] = 0; b_pipe[1] = 0;
    drv(0, 1, 0, 4095, 9'h1A5); drv(1, 1, 0, 0, 9'h05A); tick();
    drv(0, 1, 1, 0, 0);         drv(1, 1, 1, 4095, 0);   tick();
    drv(0, 1, 1, 4095, 0);      drv(1, 1, 1, 0, 0);      tick();
    idle(); tick();

    // R2: deselected writes leave words alone
    tag = "R2";
    for (int i = 0; i < 8; i++) begin
      drv(0, 0, 0, i, 9'h1FF); drv(1, 0, 0, 8 + i, 9'h1FF); tick();
    end
    for (int i = 0; i < 8; i++) begin
      drv(0, 1, 1, i, 0); drv(1, 1, 1, 8 + i, 0); tick();
    end

    // R7: write and deselect cycles keep the outputs off in both modes
    tag = "R7";
    for (int i = 0; i < 12; i++) begin
      b_pipe[0] = i[1]; b_pipe[1] = ~i[1];
      drv(0, i[0], 0, 300 + i, i * 7); drv(1, i[0], i[2] ? 1'b0 : 1'b0, 400 + i, i * 11);
      tick();
    end
    b_pipe[0] = 0; b_pipe[1] = 0;

    // R6: output enable toggling during pipelined reads
    tag = "R6";
    b_pipe[0] = 1; b_pipe[1] = 1;
    for (int i = 0; i < 24; i++) begin
      b_oe[0] = i[0]; b_oe[1] = ~i[0] | i[1];
      drv(0, 1, 1, i, 0); drv(1, 1, 1, 300 + (i % 12), 0);
      tick();
    end
    b_oe[0] = 1; b_oe[1] = 1;
    for (int i = 0; i < 4; i++) begin
      drv(0, 1, 1, i, 0); drv(1, 1, 1, 400 + i, 0); tick();
    end

    // R8: simultaneous writes to one word
    tag = "R8";
    b_pipe[0] = 0; b_pipe[1] = 0;
    for (int i = 0; i < 6; i++) begin
      drv(0, 1, 0, 100 + i, 9'h0F0 + i); drv(1, 1, 0, 100 + i, 9'h10F - i); tick();
      drv(0, 1, 1, 100 + i, 0);          drv(1, 1, 1, 100 + i, 0);          tick();
    end

    // R9: read racing a write on the other port, both modes
    tag = "R9";
    for (int m = 0; m < 2; m++) begin
      b_pipe[0] = m[0]; b_pipe[1] = m[0];
      for (int i = 0; i < 4; i++) begin
        drv(0, 1, 0, 200 + i, 9'h055 + 16 * m + i); drv(1, 1, 0, 210 + i, 9'h0AA + 16 * m + i); tick();
        drv(0, 1, 0, 200 + i, 9'h1C0 + 16 * m + i); drv(1, 1, 1, 200 + i, 0); tick();
        drv(1, 1, 0, 210 + i, 9'h13C + 16 * m + i); drv(0, 1, 1, 210 + i, 0); tick();
        idle(); tick(); tick();
      end
    end

    // R5: clock enable gaps with pending writes and held pipeline words
    tag = "R5";
    b_pipe[0] = 1; b_pipe[1] = 0;
    for (int i = 0; i < 80; i++) begin
      lf = lfsr(lf);
      b_cken[0] = lf[0] | lf[1];
      b_cken[1] = lf[2];
      drv(0, 1, 1, (i * 3) & 63, 0);
      drv(1, 1, lf[3], 32 + (i & 15), (i * 29) & 511);
      tick();
    end
    b_cken[0] = 1; b_cken[1] = 1;
    idle(); tick(); tick();

    // R2: mixed traffic on a small address window to force collisions
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        lf = lfsr(lf);
        b_cken[p] = (lf[2:0] != 3'd0);
        b_oe[p]   = lf[6] | lf[7];
        b_pipe[p] = lf[8];
        drv(p, lf[3] | lf[4], lf[5], int'(lf[12:9]), int'(lf[21:13]));
      end
      tick();
    end

    armed = 1'b0;
    summary();
    $finish;
  end

endmodule